// File: doc/BRIEF.md
# Reference Qualification Timer

This block decides whether one timing reference can be trusted by a clock-recovery loop. It watches two fault flags from the reference monitors. One flag reports a bad single period, such as a missing edge or a large phase hit. The other reports a gross frequency error seen over a short window. The block gives three results:

- `disrupted`, a combinational output. It rises in the same cycle as either flag, so the loop's mode logic can freeze into holdover at once.
- `qualified`, the slow, filtered verdict on the reference.
- `fail_time`, the current value of the fault accumulator.

A millisecond enable paces both timers. The number of ticks needed for each decision is a parameter, so a bench can shrink real time.

Faults are integrated, not timed once from the start of a fault. Each faulty tick raises an up/down accumulator by one, and each clean tick lowers it by one. Brief faults that repeat therefore still build up to disqualification. Once the reference is disqualified, a separate counter must see an unbroken run of clean ticks before the reference is trusted again. That run is four times longer than the disqualify window at the default settings. Any fault restarts the run. Out of reset the reference starts untrusted and must first complete a full clean run.

There is no data stream in this block: every pin is plain control or status, so no valid/ready handshake applies.

Top module: `ref_qual_timer`

## Requirements
- R1: `disrupted` is high in the same cycle that `cyc_fail` or `frq_fail` is high, and low when both are low, with no clock edge in between.
- R2: After reset, `qualified` is 0 and `fail_time` is 0.
- R3: On a clock edge with `ms_tick` high and either fail flag high, `fail_time` rises by one, unless it is already at DISQ_TICKS. Without `ms_tick`, `fail_time` does not change.
- R4: On a clock edge with `ms_tick` high and both fail flags low, `fail_time` falls by one, and it stays at 0 once it reaches 0.
- R5: `fail_time` never exceeds DISQ_TICKS. Further faulty ticks at that value leave it there.
- R6: While qualified, `qualified` drops one clock after `fail_time` reaches DISQ_TICKS. This holds whether the faults came in one run or in short bursts separated by clean ticks.
- R7: While disqualified, `qualified` rises one clock after the REQ_TICKS-th consecutive clean tick. On that same edge `fail_time` is cleared to 0.
- R8: Any fail flag seen while disqualified, with or without a tick, restarts the clean count from zero.
- R9: While `fail_time` is below DISQ_TICKS, faulty ticks leave a qualified reference qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle enable, once per millisecond |
| cyc_fail | input | 1 | Single-period fault flag |
| frq_fail | input | 1 | Coarse frequency fault flag |
| disrupted | output | 1 | Immediate fault indication (holdover request) |
| qualified | output | 1 | Reference judged usable |
| fail_time | output | ACC_W | Fault accumulator value in ticks |

## Verification
The case hardest to reach from the ports is disqualification by many short faults. No burst is long enough on its own to trip the limit, so the trip depends on the clean ticks between bursts falling short of undoing the fault ticks. The bench drives repeated bursts with more faulty ticks than clean ones and follows the net climb of `fail_time` tick by tick until it reaches the limit. It also breaks a clean run just before it completes, to show that a single fault restarts the requalify count.

// File: rtl/ref_qual_pkg.sv
package ref_qual_pkg;
  typedef enum logic {
    QS_UNTRUSTED = 1'b0,
    QS_TRUSTED   = 1'b1
  } qual_state_e;
endpackage

// File: rtl/fault_accum.sv
module fault_accum #(
  parameter int LIMIT = 2500,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         fault,
  input  logic         clr,
  output logic [W-1:0] acc,
  output logic         at_limit
);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
    end else if (tick) begin
      if (fault) begin
        if (acc_q < LIM_V) acc_q <= acc_q + W'(1);
      end else if (acc_q != '0) begin
        acc_q <= acc_q - W'(1);
      end
    end
  end

  assign acc      = acc_q;
  assign at_limit = (acc_q == LIM_V);

  // R5
  acc_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= LIM_V);

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(acc_q));

  // R3
  acc_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fault && !clr && acc_q < LIM_V) |=> acc_q == $past(acc_q) + W'(1));
endmodule

// File: rtl/clean_run.sv
module clean_run #(
  parameter int RUN_LEN = 10000,
  localparam int W = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fault,
  input  logic armed,
  input  logic clr,
  output logic done
);
  localparam logic [W-1:0] RUN_V = W'(RUN_LEN);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || fault || !armed) begin
      cnt_q <= '0;
    end else if (tick && cnt_q < RUN_V) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign done = (cnt_q == RUN_V);

  // R8
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> cnt_q == '0);

  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RUN_V);
endmodule

// File: rtl/qual_fsm.sv
module qual_fsm
  import ref_qual_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_full,
  input  logic run_done,
  output logic trusted,
  output logic requal
);
  qual_state_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    requal = 1'b0;
    unique case (st_q)
      QS_TRUSTED:   if (acc_full) st_d = QS_UNTRUSTED;
      QS_UNTRUSTED: if (run_done) begin
        st_d   = QS_TRUSTED;
        requal = 1'b1;
      end
      default:      st_d = QS_UNTRUSTED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= QS_UNTRUSTED;
    else        st_q <= st_d;
  end

  assign trusted = (st_q == QS_TRUSTED);

  // R6
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trusted) |-> $past(acc_full));

  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trusted) |-> $past(run_done));
endmodule

// File: rtl/ref_qual_timer.sv
module ref_qual_timer #(
  parameter int DISQ_TICKS = 2500,
  parameter int REQ_TICKS  = 10000,
  localparam int ACC_W = $clog2(DISQ_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             cyc_fail,
  input  logic             frq_fail,
  output logic             disrupted,
  output logic             qualified,
  output logic [ACC_W-1:0] fail_time
);
  logic fault;
  logic acc_full;
  logic run_done;
  logic requal;
  logic trusted;

  assign fault     = cyc_fail | frq_fail;
  assign disrupted = fault;

  fault_accum #(.LIMIT(DISQ_TICKS)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ms_tick),
    .fault    (fault),
    .clr      (requal),
    .acc      (fail_time),
    .at_limit (acc_full)
  );

  clean_run #(.RUN_LEN(REQ_TICKS)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (ms_tick),
    .fault (fault),
    .armed (!trusted),
    .clr   (requal),
    .done  (run_done)
  );

  qual_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_full (acc_full),
    .run_done (run_done),
    .trusted  (trusted),
    .requal   (requal)
  );

  assign qualified = trusted;
endmodule

// File: tb/ref_qual_timer_tb_top.sv
module ref_qual_timer_tb_top;
  localparam int L  = 20;
  localparam int RQ = 60;
  localparam int AW = $clog2(L + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic cyc_fail = 1'b0;
  logic frq_fail = 1'b0;
  logic disrupted, qualified;
  logic [AW-1:0] fail_time;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic  q;
    int    acc;
    logic  dis;
    string tag;
  } exp_t;
  exp_t sb[$];

  int  m_acc = 0;
  int  m_cln = 0;
  logic m_q = 1'b0;

  always #4 clk = ~clk;

  ref_qual_timer #(.DISQ_TICKS(L), .REQ_TICKS(RQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .cyc_fail(cyc_fail), .frq_fail(frq_fail),
    .disrupted(disrupted), .qualified(qualified), .fail_time(fail_time)
  );

  task automatic step(input logic s, input logic f, input logic t, input string tag);
    logic flt;
    exp_t e;
    @(negedge clk);
    cyc_fail = s; frq_fail = f; ms_tick = t;
    @(negedge clk);
    ms_tick = 1'b0;
    @(negedge clk);
    flt = s | f;
    if (flt) m_cln = 0;
    if (t) begin
      if (flt) begin
        if (m_acc < L) m_acc++;
      end else begin
        if (m_acc > 0) m_acc--;
        if (!m_q && m_cln < RQ) m_cln++;
      end
    end
    if (m_q && m_acc == L) m_q = 1'b0;
    else if (!m_q && m_cln == RQ) begin
      m_q = 1'b1; m_acc = 0; m_cln = 0;
    end
    e.q = m_q; e.acc = m_acc; e.dis = flt; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (qualified !== e.q || int'(fail_time) != e.acc || disrupted !== e.dis) begin
        bad++;
        $display("FAIL %s: q=%0b acc=%0d dis=%0b expected q=%0b acc=%0d dis=%0b",
                 e.tag, qualified, fail_time, disrupted, e.q, e.acc, e.dis);
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(qualified === 1'b0, "R2 qualified", int'(qualified), 0);
    chk(fail_time == '0, "R2 fail_time", int'(fail_time), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(qualified === 1'b0, "R2 after release", int'(qualified), 0);

    // R1 combinational, no clock edge between drive and sample
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cyc_fail = k[0]; frq_fail = k[1];
      #1;
      chk(disrupted === (k[0] | k[1]), "R1 disrupted", int'(disrupted), int'(k[0] | k[1]));
    end
    cyc_fail = 0; frq_fail = 0;

    // R8: clean run broken one tick before completion
    for (int i = 0; i < RQ - 1; i++) step(0, 0, 1, "R8 clean lead-in");
    step(1, 0, 0, "R8 fault without tick");
    for (int i = 0; i < RQ - 1; i++) step(0, 0, 1, "R8 restarted run");
    step(0, 1, 1, "R8 fault with tick");
    // R7: full clean run requalifies
    for (int i = 0; i < RQ; i++) step(0, 0, 1, "R7 requalify run");
    chk(qualified === 1'b1, "R7 qualified after run", int'(qualified), 1);

    // R3: faults without tick leave accumulator alone
    for (int i = 0; i < 5; i++) step(1, 1, 0, "R3 no tick");
    // R9: short faults while qualified
    for (int i = 0; i < L - 2; i++) step(0, 1, 1, "R9 below limit");
    // R4: clean ticks down to zero and stay
    for (int i = 0; i < L + 3; i++) step(0, 0, 1, "R4 decrement");

    // R6: bursts of 6 faults and 2 clean ticks accumulate
    for (int b = 0; b < 12; b++) begin
      for (int i = 0; i < 6; i++) step(1, 0, 1, "R6 burst fault");
      for (int i = 0; i < 2; i++) step(0, 0, 1, "R6 burst clean");
    end
    chk(qualified === 1'b0, "R6 disqualified by bursts", int'(qualified), 0);
    // R5: saturate at limit
    for (int i = 0; i < 8; i++) step(1, 1, 1, "R5 saturate");
    chk(int'(fail_time) == L, "R5 held at limit", int'(fail_time), L);

    // R7 again from saturated accumulator
    for (int i = 0; i < RQ; i++) step(0, 0, 1, "R7 second requalify");
    chk(qualified === 1'b1 && fail_time == '0, "R7 cleared on requalify",
        int'(fail_time), 0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule